// File: doc/BRIEF.md
# Three-Station Vote Collector

This block gathers exactly one vote from each of three stations per round and produces a single combined result once every station has voted. Each station has a vote input and an availability output. A station that is available takes the first nonzero value on its input, then closes until the round ends. Stations may vote in any order, and several may vote in the same cycle.

In the cycle after the last missing vote is taken, the block does three things together. It presents the combined result, raises a valid strobe and reopens every station for the next round. The combined result is the value shared by at least two stations, or zero when all three votes differ. A synchronous reset drops any partly collected round.

Top module: `tri_vote_unit`

## Requirements
- R1: While reset is high and in the cycle after it, every bit of `st_avail` is 1, `tally_valid` is 0 and `tally` is 0. Any votes taken before the reset are discarded.
- R2: An available station takes the value on its `st_vote` lane as its vote when that value is nonzero. From the next cycle its `st_avail` bit is 0, and it stays 0 until the round completes.
- R3: A lane value of 0 is not a vote. It leaves that station's availability and the round state unchanged.
- R4: A nonzero value on the lane of a closed station is ignored. The vote the station already holds is the one used in the result.
- R5: `tally_valid` is 1 in exactly the cycle after the cycle in which the last missing vote is taken. This holds for every arrival order, and at no other time.
- R6: In every cycle where `tally_valid` is 1, all three `st_avail` bits are 1.
- R7: When at least two of the three votes are equal, `tally` shows that value while `tally_valid` is 1. Vote values are 1, 2 and 3.
- R8: When the three votes are all different, `tally` is 0 while `tally_valid` is 1.
- R9: `tally` is 0 in every cycle where `tally_valid` is 0.
- R10: If all three stations vote in the same cycle, the result appears in the next cycle and no `st_avail` bit ever goes low. A new round may complete in the very cycle that the previous result is shown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| st_vote | input | 3 x VOTE_W | Vote lanes. Lane i is station i; 0 means no vote |
| st_avail | output | 3 | Bit i is 1 when station i can take a vote |
| tally | output | VOTE_W | Combined result, valid with `tally_valid` |
| tally_valid | output | 1 | One-cycle strobe for a completed round |

## Verification
The hardest case to reach from the ports is a closed station that keeps presenting a different nonzero value while the round is still open. That value must be shown to have had no effect. The stimulus arranges the held votes so that the ignored value would change the majority if it were taken. A wrong capture therefore shows up in `tally`.

Two other cases are also driven on purpose. The first is a reset in the middle of a round with one vote held, followed by the other two stations voting. A vote that survived the reset would then complete the round early. The second is a full three-way vote issued in the same cycle that the previous result is shown.

// File: rtl/vote_pkg.sv
package vote_pkg;
  // Number of voting stations; the round logic is defined for three.
  localparam int NUM_ST = 3;

  typedef enum logic {
    SLOT_OPEN   = 1'b0,
    SLOT_CLOSED = 1'b1
  } slot_state_t;
endpackage

// File: rtl/vote_station.sv
module vote_station #(
  parameter int VOTE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [VOTE_W-1:0] vote_in,
  input  logic              round_done,
  output logic              avail,
  output logic              acc,
  output logic              pending,
  output logic [VOTE_W-1:0] eff_vote
);
  import vote_pkg::*;

  slot_state_t      state_q;
  logic [VOTE_W-1:0] held_q;

  // A vote is taken only while the slot is open and the lane carries a value.
  assign acc      = (state_q == SLOT_OPEN) && (vote_in != '0);
  assign pending  = (state_q == SLOT_CLOSED) || acc;
  assign eff_vote = acc ? vote_in : held_q;
  assign avail    = (state_q == SLOT_OPEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SLOT_OPEN;
      held_q  <= '0;
    end else if (round_done) begin
      state_q <= SLOT_OPEN;
      held_q  <= '0;
    end else if (acc) begin
      state_q <= SLOT_CLOSED;
      held_q  <= vote_in;
    end
  end
endmodule

// File: rtl/vote_round_ctrl.sv
module vote_round_ctrl #(
  parameter int N = 3
) (
  input  logic [N-1:0] pending,
  output logic         round_done
);
  // The round closes when every station holds or is taking a vote.
  assign round_done = &pending;
endmodule

// File: rtl/vote_result.sv
module vote_result #(
  parameter int VOTE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              round_done,
  input  logic [VOTE_W-1:0] v0,
  input  logic [VOTE_W-1:0] v1,
  input  logic [VOTE_W-1:0] v2,
  output logic [VOTE_W-1:0] tally,
  output logic              tally_valid
);
  // Agreeing value of at least two votes, or zero when all differ.
  function automatic logic [VOTE_W-1:0] pick_majority(
    input logic [VOTE_W-1:0] a,
    input logic [VOTE_W-1:0] b,
    input logic [VOTE_W-1:0] c
  );
    if (a == b || a == c) return a;
    if (b == c)           return b;
    return '0;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      tally       <= '0;
      tally_valid <= 1'b0;
    end else if (round_done) begin
      tally       <= pick_majority(v0, v1, v2);
      tally_valid <= 1'b1;
    end else begin
      tally       <= '0;
      tally_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tri_vote_unit.sv
module tri_vote_unit #(
  parameter int VOTE_W = 2
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [vote_pkg::NUM_ST-1:0][VOTE_W-1:0] st_vote,
  output logic [vote_pkg::NUM_ST-1:0]         st_avail,
  output logic [VOTE_W-1:0]                   tally,
  output logic                                tally_valid
);
  import vote_pkg::*;

  logic [NUM_ST-1:0]             acc_evt;
  logic [NUM_ST-1:0]             pend;
  logic [NUM_ST-1:0][VOTE_W-1:0] eff;
  logic                          round_done;

  for (genvar i = 0; i < NUM_ST; i++) begin : g_st
    vote_station #(.VOTE_W(VOTE_W)) u_st (
      .clk       (clk),
      .rst       (rst),
      .vote_in   (st_vote[i]),
      .round_done(round_done),
      .avail     (st_avail[i]),
      .acc       (acc_evt[i]),
      .pending   (pend[i]),
      .eff_vote  (eff[i])
    );
  end

  vote_round_ctrl #(.N(NUM_ST)) u_ctrl (
    .pending   (pend),
    .round_done(round_done)
  );

  vote_result #(.VOTE_W(VOTE_W)) u_res (
    .clk        (clk),
    .rst        (rst),
    .round_done (round_done),
    .v0         (eff[0]),
    .v1         (eff[1]),
    .v2         (eff[2]),
    .tally      (tally),
    .tally_valid(tally_valid)
  );
endmodule

// File: rtl/tri_vote_checker.sv
module tri_vote_checker #(
  parameter int VOTE_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        st_avail,
  input logic [VOTE_W-1:0] tally,
  input logic              tally_valid,
  input logic [2:0]        acc_evt,
  input logic              round_done
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (st_avail == 3'b111 && !tally_valid && tally == '0));

  assert_close_after_take_R2: assert property (@(posedge clk) disable iff (rst)
    ((acc_evt != 3'b000) && !round_done) |=> ((st_avail & $past(acc_evt)) == 3'b000));

  assert_no_early_reopen_R2: assert property (@(posedge clk) disable iff (rst)
    !round_done |=> ((st_avail & ~$past(st_avail)) == 3'b000));

  assert_closed_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (acc_evt & ~st_avail) == 3'b000);

  assert_valid_follows_R5: assert property (@(posedge clk) disable iff (rst)
    round_done |=> tally_valid);

  assert_valid_cause_R5: assert property (@(posedge clk) disable iff (rst)
    tally_valid |-> $past(round_done));

  assert_reopen_all_R6: assert property (@(posedge clk) disable iff (rst)
    tally_valid |-> (st_avail == 3'b111));

  assert_quiet_tally_R9: assert property (@(posedge clk) disable iff (rst)
    !tally_valid |-> (tally == '0));
endmodule

bind tri_vote_unit tri_vote_checker #(.VOTE_W(VOTE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .st_avail   (st_avail),
  .tally      (tally),
  .tally_valid(tally_valid),
  .acc_evt    (acc_evt),
  .round_done (round_done)
);

// File: tb/tb_tri_vote_unit.sv
`timescale 1ns/1ps
module tb_tri_vote_unit;
  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [2:0][1:0] st_vote = '0;
  logic [2:0]      st_avail;
  logic [1:0]      tally;
  logic            tally_valid;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // Reference model state
  int got[3];
  int val[3];
  int exp_valid = 0;
  int exp_tally = 0;

  always #2 clk = ~clk;

  tri_vote_unit #(.VOTE_W(2)) dut (
    .clk(clk), .rst(rst), .st_vote(st_vote),
    .st_avail(st_avail), .tally(tally), .tally_valid(tally_valid)
  );

  function automatic int ref_majority(int a, int b, int c);
    int cnt[4];
    for (int k = 0; k < 4; k++) cnt[k] = 0;
    cnt[a]++; cnt[b]++; cnt[c]++;
    for (int k = 1; k < 4; k++) if (cnt[k] >= 2) return k;
    return 0;
  endfunction

  task automatic model_update(input int r, input int a, input int b, input int c);
    int in[3];
    in[0] = a; in[1] = b; in[2] = c;
    if (r != 0) begin
      for (int k = 0; k < 3; k++) begin got[k] = 0; val[k] = 0; end
      exp_valid = 0; exp_tally = 0;
    end else begin
      for (int k = 0; k < 3; k++)
        if (got[k] == 0 && in[k] != 0) begin got[k] = 1; val[k] = in[k]; end
      if (got[0] == 1 && got[1] == 1 && got[2] == 1) begin
        exp_valid = 1;
        exp_tally = ref_majority(val[0], val[1], val[2]);
        for (int k = 0; k < 3; k++) begin got[k] = 0; val[k] = 0; end
      end else begin
        exp_valid = 0; exp_tally = 0;
      end
    end
  endtask

  task automatic compare(input string tag);
    for (int k = 0; k < 3; k++) begin
      vectors++;
      if (int'(st_avail[k]) != 1 - got[k]) begin
        miscompares++;
        $display("FAIL %s (R2 avail[%0d]) actual=%0d expected=%0d", tag, k, st_avail[k], 1 - got[k]);
      end
    end
    vectors++;
    if (int'(tally_valid) != exp_valid) begin
      miscompares++;
      $display("FAIL %s (R5 valid) actual=%0d expected=%0d", tag, tally_valid, exp_valid);
    end
    vectors++;
    if (int'(tally) != exp_tally) begin
      miscompares++;
      $display("FAIL %s (R7 tally) actual=%0d expected=%0d", tag, tally, exp_tally);
    end
  endtask

  // Drive one cycle of inputs, advance the clock, then compare with the model.
  task automatic step(input int r, input int a, input int b, input int c, input string tag);
    rst = (r != 0);
    st_vote[0] = 2'(a); st_vote[1] = 2'(b); st_vote[2] = 2'(c);
    @(posedge clk);
    model_update(r, a, b, c);
    #1;
    compare(tag);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #40000;
    miscompares++;
    $display("FAIL watchdog expired (R5) actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 3; k++) begin got[k] = 0; val[k] = 0; end
    #1;
    step(1, 0, 0, 0, "R1 reset");
    step(1, 2, 3, 1, "R1 reset with lanes busy");
    step(0, 0, 0, 0, "R1 after reset");
    step(0, 0, 0, 0, "R3 idle");

    // Ordered arrivals, majority 1
    step(0, 1, 0, 0, "R2 s0 votes");
    step(0, 0, 0, 0, "R3 zero lanes keep state");
    step(0, 0, 1, 0, "R2 s1 votes");
    step(0, 0, 0, 2, "R5 last vote s2");
    step(0, 0, 0, 0, "R6 R7 result 1");
    step(0, 0, 0, 0, "R9 quiet");

    // Reverse order, majority via b==c
    step(0, 0, 0, 3, "R2 s2 first");
    step(0, 0, 3, 0, "R2 s1 second");
    step(0, 0, 0, 0, "R3 wait");
    step(0, 2, 0, 0, "R5 s0 last");
    step(0, 0, 0, 0, "R7 result 3");

    // All different
    step(0, 0, 2, 0, "R2 s1");
    step(0, 1, 0, 3, "R5 two together complete");
    step(0, 0, 0, 0, "R8 all differ gives 0");

    // Closed station presents a new value that would change the majority
    step(0, 1, 0, 0, "R4 s0 takes 1");
    step(0, 3, 1, 0, "R4 s0 closed shows 3");
    step(0, 3, 0, 0, "R4 s0 closed shows 3 again");
    step(0, 3, 0, 3, "R4 s2 completes");
    step(0, 0, 0, 0, "R4 R7 result must be 1");

    // Same-cycle round, then back-to-back round in the valid cycle
    step(0, 2, 2, 2, "R10 all at once");
    step(0, 3, 1, 3, "R10 back to back");
    step(0, 0, 0, 0, "R10 second result");
    step(0, 0, 0, 0, "R9 quiet");

    // Reset in the middle of a round
    step(0, 1, 0, 0, "R1 s0 votes before reset");
    step(1, 0, 0, 0, "R1 mid-round reset");
    step(0, 0, 2, 2, "R1 only two after reset");
    step(0, 0, 0, 0, "R1 no completion expected");
    step(0, 3, 0, 0, "R1 s0 fresh vote");
    step(0, 0, 0, 0, "R7 result 2");

    for (int n = 0; n < 24; n++)
      step(0, (n * 7) % 4, (n * 5 + 1) % 4, (n * 3 + 2) % 4, "R7 mixed pattern");
    step(0, 0, 0, 0, "R9 final");
    finish_run();
  end
endmodule